// File: doc/BRIEF.md
# Host/Device Ring Mailbox

This block is a mailbox between a host processor and an embedded controller. It holds two independent circular buffers of 32-bit slots. The host fills the outbound ring by writing a write-window register, and the controller drains it through a pop port. The controller fills the inbound ring through a push port, and the host drains it by reading a read-window register. A message is a header slot followed by payload slots. A trailing partial word takes one whole padded slot. Framing above the slot level belongs to software.

Each side has a status word that the host can read. It shows the ring's fixed capacity, and its raw 8-bit producer and consumer pointers. Software computes occupancy as the producer pointer minus the consumer pointer, modulo 256. It treats any result above the capacity as an error, never as a count. The host control word also carries these bits:
- an interrupt enable,
- a write-one-to-clear interrupt status, set by the controller's doorbell,
- an interrupt-generate bit, which rings the controller's doorbell,
- a host-ready flag,
- a reset request that empties both rings.

Top module: `mbox_top`

## Requirements
- R1: After reset, the host control word (address 2) reads capacity << 24 with all other bits zero. The device status word (address 3) reads its capacity << 24 with all other bits zero. The host interrupt is low.
- R2: Each host write to address 0 stores one slot in the outbound ring and advances the outbound producer pointer (host control word bits 23:16). The controller's pop port presents the slots in write order, and each pop advances the consumer pointer (bits 15:8).
- R3: Each device push stores one slot in the inbound ring. A host read of address 1 returns the oldest slot and advances the inbound consumer pointer. Device status word bits 23:16 hold the producer pointer and bits 15:8 hold the consumer pointer.
- R4: The pointers are 8-bit counters that wrap modulo 256. Data order and the occupancy (producer minus consumer) stay correct across the wrap.
- R5: A push into a ring whose occupancy equals its capacity is dropped. For the outbound ring this sets a sticky overflow bit (host control word bit 5), which writing 1 to that bit clears. The occupancy never exceeds the capacity.
- R6: A pop from an empty ring returns zero and leaves both pointers unchanged. This holds for the host read window and for the device pop port.
- R7: Writing 1 to host control word bit 2 (interrupt generate) pulses the device doorbell output high for exactly one cycle. The bit reads back as zero.
- R8: A device doorbell sets the interrupt status (bit 1). The host interrupt equals status AND enable (bit 0). Writing 1 to bit 1 clears the status and writing 0 leaves it. A doorbell in the same cycle as the clear wins.
- R9: Writing 1 to host control word bit 4 (reset) empties both rings, clears the host-ready bit, device-ready and the overflow flags. All of this happens at that same clock edge. While the bit stays set, pushes are ignored and the device reset output is high.
- R10: Host writes to control word bits 31:8 have no effect. The capacity field is constant and the pointers move only by push and pop.
- R11: A device-ready pulse sets device status word bit 3. Host control word bit 3 (host ready) is host-writable and is driven on an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 2 | Register word address: 0 write window, 1 read window, 2 host control, 3 device status |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (pops at address 1) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from the address |
| hostIrq | output | 1 | Host interrupt |
| devPopEn | input | 1 | Controller pops the outbound ring |
| devPopData | output | 32 | Oldest outbound slot, zero when empty |
| devPushEn | input | 1 | Controller pushes the inbound ring |
| devPushData | input | 32 | Slot pushed by the controller |
| devDoorbellIn | input | 1 | Controller doorbell toward the host |
| devReadyIn | input | 1 | Controller reports ready (pulse) |
| devDoorbellOut | output | 1 | One-cycle doorbell toward the controller |
| devResetOut | output | 1 | Reset request held toward the controller |
| devHostReady | output | 1 | Host-ready flag |

## Verification
Read data, device pop data and status words are combinational from the current state. They are sampled during the low phase of the strobe's own cycle, before the edge that moves a pointer. Pointer, flag and interrupt changes appear one edge after the strobe. They are sampled at the following falling edge. The doorbell output rises at the edge that takes the control write and falls one edge later. The bench therefore samples it high at the first falling edge and low at the second. Reset clears both rings at the edge of the reset write, so the status words show zero pointers at the next falling edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_WWIN = 2'd0;
  localparam logic [ADDR_W-1:0] A_RWIN = 2'd1;
  localparam logic [ADDR_W-1:0] A_HCSR = 2'd2;
  localparam logic [ADDR_W-1:0] A_DCSR = 2'd3;

  localparam int B_INTEN  = 0;
  localparam int B_INTSTS = 1;
  localparam int B_INTGEN = 2;
  localparam int B_READY  = 3;
  localparam int B_RESET  = 4;
  localparam int B_OVF    = 5;

  typedef struct packed {
    logic h2dPush;
    logic h2dPop;
    logic d2hPush;
    logic d2hPop;
    logic flush;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     push,
  input  logic [WIDTH-1:0]         pushData,
  input  logic                     pop,
  output logic [WIDTH-1:0]         popData,
  output logic [mbox_pkg::PTR_W-1:0] wrPtr,
  output logic [mbox_pkg::PTR_W-1:0] rdPtr,
  output logic                     pushDrop
);
  localparam int PTR_W = mbox_pkg::PTR_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

  initial begin
    assert (DEPTH >= 2 && DEPTH <= 128 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("ring capacity must be a power of two from 2 to 128");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] fill;
  logic full, empty, doPush, doPop;

  assign fill     = wrPtr - rdPtr;
  assign full     = (fill == CAP);
  assign empty    = (fill == '0);
  assign doPush   = push && !full && !flush;
  assign doPop    = pop && !empty && !flush;
  assign pushDrop = push && full && !flush;
  assign popData  = empty ? '0 : mem[rdPtr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[IDX_W-1:0]] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= CAP);

  // R6
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !flush) |=> (rdPtr == $past(rdPtr)));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (wrPtr == '0 && rdPtr == '0));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int H2D_DEPTH = 16,
  parameter int D2H_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strobe,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] devPushData,
  output logic [DATA_W-1:0] h2dHead,
  output logic [DATA_W-1:0] d2hHead,
  output logic [PTR_W-1:0]  h2dWp,
  output logic [PTR_W-1:0]  h2dRp,
  output logic [PTR_W-1:0]  d2hWp,
  output logic [PTR_W-1:0]  d2hRp,
  output logic              h2dDrop,
  output logic              d2hDrop
);
  mbox_ring #(.DEPTH(H2D_DEPTH), .WIDTH(DATA_W)) u_h2dRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.flush),
    .push     (strobe.h2dPush),
    .pushData (hostWdata),
    .pop      (strobe.h2dPop),
    .popData  (h2dHead),
    .wrPtr    (h2dWp),
    .rdPtr    (h2dRp),
    .pushDrop (h2dDrop)
  );

  mbox_ring #(.DEPTH(D2H_DEPTH), .WIDTH(DATA_W)) u_d2hRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.flush),
    .push     (strobe.d2hPush),
    .pushData (devPushData),
    .pop      (strobe.d2hPop),
    .popData  (d2hHead),
    .wrPtr    (d2hWp),
    .rdPtr    (d2hRp),
    .pushDrop (d2hDrop)
  );
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int H2D_DEPTH = 16,
  parameter int D2H_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  input  logic              devPopEn,
  input  logic              devPushEn,
  input  logic              devDoorbellIn,
  input  logic              devReadyIn,
  output logic              devDoorbellOut,
  output logic              devResetOut,
  output logic              devHostReady,
  input  logic [DATA_W-1:0] d2hHead,
  input  logic [PTR_W-1:0]  h2dWp,
  input  logic [PTR_W-1:0]  h2dRp,
  input  logic [PTR_W-1:0]  d2hWp,
  input  logic [PTR_W-1:0]  d2hRp,
  input  logic              h2dDrop,
  input  logic              d2hDrop,
  output mbox_strobe_t      strobe
);
  localparam logic [PTR_W-1:0] H2D_CAP = PTR_W'(H2D_DEPTH);
  localparam logic [PTR_W-1:0] D2H_CAP = PTR_W'(D2H_DEPTH);

  logic intEnable, intStatus, hostReady, resetBit, hostOvf, devOvf, devReady;
  logic csrWr, nextReset, flushNow;
  logic [DATA_W-1:0] hostCsr, devCsr;

  assign csrWr     = hostWrEn && (hostAddr == A_HCSR);
  assign nextReset = csrWr ? hostWdata[B_RESET] : resetBit;
  assign flushNow  = resetBit || (csrWr && hostWdata[B_RESET]);

  always_comb begin
    strobe.h2dPush = hostWrEn && (hostAddr == A_WWIN);
    strobe.h2dPop  = devPopEn;
    strobe.d2hPush = devPushEn;
    strobe.d2hPop  = hostRdEn && (hostAddr == A_RWIN);
    strobe.flush   = flushNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable      <= 1'b0;
      intStatus      <= 1'b0;
      hostReady      <= 1'b0;
      resetBit       <= 1'b0;
      hostOvf        <= 1'b0;
      devOvf         <= 1'b0;
      devReady       <= 1'b0;
      devDoorbellOut <= 1'b0;
    end else begin
      devDoorbellOut <= csrWr && hostWdata[B_INTGEN];
      if (csrWr) begin
        intEnable <= hostWdata[B_INTEN];
        resetBit  <= hostWdata[B_RESET];
      end

      if (nextReset)  hostReady <= 1'b0;
      else if (csrWr) hostReady <= hostWdata[B_READY];

      if (devDoorbellIn)                      intStatus <= 1'b1;
      else if (csrWr && hostWdata[B_INTSTS])  intStatus <= 1'b0;

      if (flushNow)                        hostOvf <= 1'b0;
      else if (h2dDrop)                    hostOvf <= 1'b1;
      else if (csrWr && hostWdata[B_OVF])  hostOvf <= 1'b0;

      if (flushNow)     devOvf <= 1'b0;
      else if (d2hDrop) devOvf <= 1'b1;

      if (nextReset)       devReady <= 1'b0;
      else if (devReadyIn) devReady <= 1'b1;
    end
  end

  assign hostCsr = {H2D_CAP, h2dWp, h2dRp, 2'b00, hostOvf, resetBit,
                    hostReady, 1'b0, intStatus, intEnable};
  assign devCsr  = {D2H_CAP, d2hWp, d2hRp, 2'b00, devOvf, 1'b0,
                    devReady, 3'b000};

  always_comb begin
    unique case (hostAddr)
      A_WWIN:  hostRdata = '0;
      A_RWIN:  hostRdata = d2hHead;
      A_HCSR:  hostRdata = hostCsr;
      default: hostRdata = devCsr;
    endcase
  end

  assign hostIrq      = intStatus && intEnable;
  assign devResetOut  = resetBit;
  assign devHostReady = hostReady;

  // R8
  doorbell_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    devDoorbellIn |=> hostRdata[B_INTSTS] || (hostAddr != A_HCSR));

  // R7
  intgen_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWr && hostWdata[B_INTGEN]) |=> devDoorbellOut);

  // R7
  intgen_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(csrWr && hostWdata[B_INTGEN]) |=> !devDoorbellOut);

  // R9
  reset_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWr && hostWdata[B_RESET]) |=> (!devHostReady && devResetOut));
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int H2D_DEPTH = 16,
  parameter int D2H_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostIrq,
  input  logic        devPopEn,
  output logic [31:0] devPopData,
  input  logic        devPushEn,
  input  logic [31:0] devPushData,
  input  logic        devDoorbellIn,
  input  logic        devReadyIn,
  output logic        devDoorbellOut,
  output logic        devResetOut,
  output logic        devHostReady
);
  mbox_strobe_t strobe;
  logic [DATA_W-1:0] d2hHead;
  logic [PTR_W-1:0]  h2dWp, h2dRp, d2hWp, d2hRp;
  logic              h2dDrop, d2hDrop;

  mbox_ctrl #(.H2D_DEPTH(H2D_DEPTH), .D2H_DEPTH(D2H_DEPTH)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .hostAddr       (hostAddr),
    .hostWrEn       (hostWrEn),
    .hostRdEn       (hostRdEn),
    .hostWdata      (hostWdata),
    .hostRdata      (hostRdata),
    .hostIrq        (hostIrq),
    .devPopEn       (devPopEn),
    .devPushEn      (devPushEn),
    .devDoorbellIn  (devDoorbellIn),
    .devReadyIn     (devReadyIn),
    .devDoorbellOut (devDoorbellOut),
    .devResetOut    (devResetOut),
    .devHostReady   (devHostReady),
    .d2hHead        (d2hHead),
    .h2dWp          (h2dWp),
    .h2dRp          (h2dRp),
    .d2hWp          (d2hWp),
    .d2hRp          (d2hRp),
    .h2dDrop        (h2dDrop),
    .d2hDrop        (d2hDrop),
    .strobe         (strobe)
  );

  mbox_datapath #(.H2D_DEPTH(H2D_DEPTH), .D2H_DEPTH(D2H_DEPTH)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostWdata   (hostWdata),
    .devPushData (devPushData),
    .h2dHead     (devPopData),
    .d2hHead     (d2hHead),
    .h2dWp       (h2dWp),
    .h2dRp       (h2dRp),
    .d2hWp       (d2hWp),
    .d2hRp       (d2hRp),
    .h2dDrop     (h2dDrop),
    .d2hDrop     (d2hDrop)
  );
endmodule

// File: tb/mbox_top_bench.sv
module mbox_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq;
  logic        devPopEn = 1'b0, devPushEn = 1'b0;
  logic [31:0] devPopData;
  logic [31:0] devPushData = '0;
  logic        devDoorbellIn = 1'b0, devReadyIn = 1'b0;
  logic        devDoorbellOut, devResetOut, devHostReady;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbox_top u_mbox_top (.*);

  // op: 0 host write window, 1 device push, 2 host read window (expect),
  //     3 device pop (expect), 4 host control word (expect), 5 device status (expect)
  localparam logic [34:0] VEC [17] = '{
    {3'd4, 32'h1000_0000},
    {3'd0, 32'hA1A1_0001},
    {3'd0, 32'hA2A2_0002},
    {3'd4, 32'h1002_0000},
    {3'd3, 32'hA1A1_0001},
    {3'd3, 32'hA2A2_0002},
    {3'd4, 32'h1002_0200},
    {3'd1, 32'hB1B1_0011},
    {3'd1, 32'hB2B2_0012},
    {3'd5, 32'h1002_0000},
    {3'd2, 32'hB1B1_0011},
    {3'd2, 32'hB2B2_0012},
    {3'd5, 32'h1002_0200},
    {3'd2, 32'h0000_0000},
    {3'd5, 32'h1002_0200},
    {3'd3, 32'h0000_0000},
    {3'd4, 32'h1002_0200}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdata;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic devPush(input logic [31:0] d);
    @(negedge clk);
    devPushData = d; devPushEn = 1'b1;
    @(posedge clk); #1;
    devPushEn = 1'b0;
  endtask

  task automatic devPop(output logic [31:0] d);
    @(negedge clk);
    devPopEn = 1'b1;
    #1 d = devPopData;
    @(posedge clk); #1;
    devPopEn = 1'b0;
  endtask

  task automatic devPulse(input bit bell, input bit rdy);
    @(negedge clk);
    devDoorbellIn = bell; devReadyIn = rdy;
    @(posedge clk); #1;
    devDoorbellIn = 1'b0; devReadyIn = 1'b0;
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, hostIrq}, 32'h0);
    hostRead(2'd3, r);
    chk("R1 device status after reset", r, 32'h1000_0000);

    // table walk: R1, R2, R3, R6
    for (int i = 0; i < 17; i++) begin
      logic [2:0]  op;
      logic [31:0] v;
      op = VEC[i][34:32];
      v  = VEC[i][31:0];
      case (op)
        3'd0: hostWrite(2'd0, v);
        3'd1: devPush(v);
        3'd2: begin hostRead(2'd1, r); chk("R3/R6 read window", r, v); end
        3'd3: begin devPop(r); chk("R2/R6 device pop", r, v); end
        3'd4: begin hostRead(2'd2, r); chk("R2/R1 host control word", r, v); end
        default: begin hostRead(2'd3, r); chk("R3/R6 device status", r, v); end
      endcase
    end

    // R7 doorbell toward device
    hostWrite(2'd2, 32'h0000_0004);
    @(negedge clk);
    chk("R7 doorbell high", {31'b0, devDoorbellOut}, 32'h1);
    @(negedge clk);
    chk("R7 doorbell one cycle", {31'b0, devDoorbellOut}, 32'h0);
    hostRead(2'd2, r);
    chk("R7 intgen reads zero", r & 32'h4, 32'h0);

    // R8 interrupt status/enable
    devPulse(1'b1, 1'b0);
    @(negedge clk);
    chk("R8 masked irq", {31'b0, hostIrq}, 32'h0);
    hostRead(2'd2, r);
    chk("R8 status set", r & 32'h3, 32'h2);
    hostWrite(2'd2, 32'h0000_0001);
    @(negedge clk);
    chk("R8 irq when enabled", {31'b0, hostIrq}, 32'h1);
    hostWrite(2'd2, 32'h0000_0003);
    @(negedge clk);
    chk("R8 w1c clears irq", {31'b0, hostIrq}, 32'h0);
    @(negedge clk);
    devDoorbellIn = 1'b1; hostAddr = 2'd2; hostWdata = 32'h3; hostWrEn = 1'b1;
    @(posedge clk); #1;
    devDoorbellIn = 1'b0; hostWrEn = 1'b0;
    @(negedge clk);
    chk("R8 doorbell beats clear", {31'b0, hostIrq}, 32'h1);
    hostWrite(2'd2, 32'h0000_0003);

    // R5 full ring drops and flags (wp 2 -> 18, one extra dropped)
    for (int i = 0; i < 17; i++) hostWrite(2'd0, 32'hC000_0000 + i);
    hostRead(2'd2, r);
    chk("R5 full and overflow flag", r & 32'hFFFF_FF20, 32'h1012_0220);
    hostWrite(2'd2, 32'h0000_0021);
    hostRead(2'd2, r);
    chk("R5 overflow w1c", r & 32'h20, 32'h0);
    for (int i = 0; i < 16; i++) begin
      devPop(r);
      if (i == 0 || i == 15) chk("R5 ring contents after drop", r, 32'hC000_0000 + i);
    end

    // R4 pointer wrap: 260 more slots through the outbound ring
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 260; i++) begin
        hostWrite(2'd0, 32'hD000_0000 + i);
        devPop(r);
        if (r !== 32'hD000_0000 + i) bad++;
      end
      chk("R4 data order across wrap", bad, 0);
    end
    hostRead(2'd2, r);
    chk("R4 wrapped pointers", r & 32'hFFFF_FF00, 32'h1016_1600);

    // R11 ready flags
    devPulse(1'b0, 1'b1);
    hostRead(2'd3, r);
    chk("R11 device ready", r & 32'h8, 32'h8);
    hostWrite(2'd2, 32'h0000_0009);
    @(negedge clk);
    chk("R11 host ready output", {31'b0, devHostReady}, 32'h1);

    // R9 reset request
    hostWrite(2'd0, 32'hE000_0001);
    devPush(32'hE000_0002);
    hostWrite(2'd2, 32'h0000_0015);
    hostRead(2'd2, r);
    chk("R9 host word after reset", r & 32'hFFFF_FF18, 32'h1000_0010);
    hostRead(2'd3, r);
    chk("R9 device word after reset", r & 32'h00FF_FF08, 32'h0);
    chk("R9 reset output", {31'b0, devResetOut}, 32'h1);
    hostWrite(2'd0, 32'hE000_0003);
    devPush(32'hE000_0004);
    hostRead(2'd2, r);
    chk("R9 push ignored in reset", r & 32'h00FF_FF00, 32'h0);
    hostRead(2'd3, r);
    chk("R9 device push ignored in reset", r & 32'h00FF_FF00, 32'h0);
    hostWrite(2'd2, 32'h0000_000D);
    hostRead(2'd2, r);
    chk("R9 release", r & 32'hFFFF_FF18, 32'h1000_0008);
    chk("R9 reset output released", {31'b0, devResetOut}, 32'h0);

    // R10 upper control bits are not writable
    hostWrite(2'd2, 32'hFFFF_FF09);
    hostRead(2'd2, r);
    chk("R10 depth and pointers unchanged", r & 32'hFFFF_FF00, 32'h1000_0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule